// File: doc/BRIEF.md
# Sub-Dword Operand Select and Merge

This datapath stage sits on both sides of a 32-bit ALU. On the way in, it prepares each of two source operands. The operand is either the whole 32-bit word or one of its bytes or 16-bit halves. A sub-dword field moves down to the low end of the operand. Above the field the operand is filled with zeros, or with copies of the field's top bit when that operand's sign flag is set.

On the way out, the stage takes the low bits of the ALU result and writes them into a chosen byte, half or whole word of the destination. The bits outside that field follow one of three policies:
- cleared to zero;
- sign-filled above the field and cleared below it;
- kept from the old destination value, which is the default policy.

Code values that are not defined raise a flag, and the stage then behaves as the whole-word case. The ALU itself is not part of this block. The outputs pass through a register stage by default. That register can be removed with a parameter, which makes the stage purely combinational.

Top module: `subdw_sel_merge`

## Requirements
- R1: Lane select codes (3 bits) are 0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16, 3 = bits 31:24, 4 = bits 15:0, 5 = bits 31:16 and 6 = the whole word. A byte or half field without the sign flag appears in the low bits of the operand, with zeros above it.
- R2: With the sign flag set, a byte or half source field is sign-extended to 32 bits.
- R3: With code 6, the operand equals the source word, whatever the value of the sign flag.
- R4: For a sub-dword destination code, the low 8 or 16 bits of the ALU result appear at the selected field position of the merged output.
- R5: Fill policy 0 (zero) clears every merged bit outside the field.
- R6: Fill policy 1 (sign) sets every bit above the field to the field's top bit and clears every bit below the field.
- R7: Fill policy 2 (keep) takes every bit outside the field from the old destination value.
- R8: With destination code 6, the merged output equals the ALU result under every fill policy.
- R9: Lane code 7 and fill code 3 set the illegal flag. Lane code 7 then acts as code 6 and fill code 3 acts as policy 2. Legal codes leave the flag clear.
- R10: With the default OUT_REG=1, the outputs show the result for the inputs one clock edge later. While reset is held, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src0 | input | 32 | First source word |
| src0_sel | input | 3 | Lane select for the first source |
| src0_sext | input | 1 | Sign flag for the first source |
| src1 | input | 32 | Second source word |
| src1_sel | input | 3 | Lane select for the second source |
| src1_sext | input | 1 | Sign flag for the second source |
| alu_res | input | 32 | Raw ALU result |
| dst_old | input | 32 | Old destination value |
| dst_sel | input | 3 | Destination field select |
| dst_fill | input | 2 | Policy for the bits outside the destination field |
| opnd0 | output | 32 | Prepared first operand |
| opnd1 | output | 32 | Prepared second operand |
| dst_out | output | 32 | Merged destination |
| sel_illegal | output | 1 | An undefined select or fill code is present |

## Verification
The properties assume the registered build. They also assume that every input stays constant between the rising edges where it is sampled. Under those two conditions, each output one edge later can be related to the inputs seen at the previous edge.

The bench changes inputs only on falling edges, and it releases reset away from the rising edge. Its stimulus covers all eight lane codes and all four fill codes, including the undefined ones. Directed vectors set field top bits both high and low. Seeded random vectors draw from the full code space.

// File: rtl/subdw_pkg.sv
package subdw_pkg;
  typedef enum logic [2:0] {
    LANE_B0 = 3'd0,
    LANE_B1 = 3'd1,
    LANE_B2 = 3'd2,
    LANE_B3 = 3'd3,
    LANE_H0 = 3'd4,
    LANE_H1 = 3'd5,
    LANE_DW = 3'd6,
    LANE_XX = 3'd7
  } lane_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_KEEP = 2'd2,
    FILL_XX   = 2'd3
  } fill_e;
endpackage

// File: rtl/subdw_src_extract.sv
module subdw_src_extract
  import subdw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] src,
  input  logic [2:0]    sel,
  input  logic          sext,
  output logic [DW-1:0] opnd,
  output logic          bad
);
  localparam int BW = DW / 4;
  localparam int HW = DW / 2;

  logic [BW-1:0] byte_f;
  logic [HW-1:0] half_f;
  lane_e         lane;

  always_comb begin
    lane   = lane_e'(sel);
    byte_f = src[sel[1:0]*BW +: BW];
    half_f = src[sel[0]*HW +: HW];
    bad    = (lane == LANE_XX);
    unique case (lane)
      LANE_B0, LANE_B1, LANE_B2, LANE_B3:
        opnd = {{(DW-BW){sext & byte_f[BW-1]}}, byte_f};
      LANE_H0, LANE_H1:
        opnd = {{(DW-HW){sext & half_f[HW-1]}}, half_f};
      default:
        opnd = src;
    endcase
  end
endmodule

// File: rtl/subdw_dst_merge.sv
module subdw_dst_merge
  import subdw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] res,
  input  logic [DW-1:0] old,
  input  logic [2:0]    sel,
  input  logic [1:0]    fill,
  output logic [DW-1:0] dst,
  output logic          bad
);
  localparam int IW = $clog2(DW);
  localparam logic [IW-1:0] BW_L  = IW'(DW / 4);
  localparam logic [IW-1:0] HW_L  = IW'(DW / 2);
  localparam logic [IW-1:0] TOP_L = IW'(DW - 1);

  lane_e         lane;
  fill_e         pol;
  logic [IW-1:0] lo;
  logic [IW-1:0] hi;
  logic [DW-1:0] shifted;
  logic [DW-1:0] below_m;
  logic [DW-1:0] field_m;
  logic [DW-1:0] above_m;
  logic          top_bit;

  always_comb begin
    lane = lane_e'(sel);
    pol  = fill_e'(fill);
    unique case (lane)
      LANE_B0, LANE_B1, LANE_B2, LANE_B3: begin
        lo = IW'(sel[1:0]) * BW_L;
        hi = lo + (BW_L - IW'(1));
      end
      LANE_H0, LANE_H1: begin
        lo = IW'(sel[0]) * HW_L;
        hi = lo + (HW_L - IW'(1));
      end
      default: begin
        lo = '0;
        hi = TOP_L;
      end
    endcase
    shifted = res << lo;
    below_m = ~({DW{1'b1}} << lo);
    field_m = ({DW{1'b1}} >> (TOP_L - hi)) & ~below_m;
    above_m = ~(field_m | below_m);
    top_bit = shifted[hi];
    bad     = (lane == LANE_XX) || (pol == FILL_XX);
    unique case (pol)
      FILL_ZERO: dst = shifted & field_m;
      FILL_SIGN: dst = (shifted & field_m) | (top_bit ? above_m : '0);
      default:   dst = (shifted & field_m) | (old & ~field_m);
    endcase
  end
endmodule

// File: rtl/subdw_sel_merge.sv
module subdw_sel_merge #(
  parameter int DW      = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src0,
  input  logic [2:0]    src0_sel,
  input  logic          src0_sext,
  input  logic [DW-1:0] src1,
  input  logic [2:0]    src1_sel,
  input  logic          src1_sext,
  input  logic [DW-1:0] alu_res,
  input  logic [DW-1:0] dst_old,
  input  logic [2:0]    dst_sel,
  input  logic [1:0]    dst_fill,
  output logic [DW-1:0] opnd0,
  output logic [DW-1:0] opnd1,
  output logic [DW-1:0] dst_out,
  output logic          sel_illegal
);
  localparam int NSRC = 2;

  logic [DW-1:0] src_w  [NSRC];
  logic [2:0]    sel_w  [NSRC];
  logic          sx_w   [NSRC];
  logic [DW-1:0] opnd_d [NSRC];
  logic          bad_s  [NSRC];
  logic [DW-1:0] dst_d;
  logic          bad_d;
  logic          ill_d;

  assign src_w[0] = src0;
  assign src_w[1] = src1;
  assign sel_w[0] = src0_sel;
  assign sel_w[1] = src1_sel;
  assign sx_w[0]  = src0_sext;
  assign sx_w[1]  = src1_sext;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    subdw_src_extract #(.DW(DW)) u_ext (
      .src  (src_w[k]),
      .sel  (sel_w[k]),
      .sext (sx_w[k]),
      .opnd (opnd_d[k]),
      .bad  (bad_s[k])
    );
  end

  subdw_dst_merge #(.DW(DW)) u_merge (
    .res  (alu_res),
    .old  (dst_old),
    .sel  (dst_sel),
    .fill (dst_fill),
    .dst  (dst_d),
    .bad  (bad_d)
  );

  assign ill_d = bad_s[0] | bad_s[1] | bad_d;

  if (OUT_REG) begin : g_reg
    logic [DW-1:0] op0_q, op1_q, dst_q;
    logic          ill_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        op0_q <= '0;
        op1_q <= '0;
        dst_q <= '0;
        ill_q <= 1'b0;
      end else begin
        op0_q <= opnd_d[0];
        op1_q <= opnd_d[1];
        dst_q <= dst_d;
        ill_q <= ill_d;
      end
    end
    assign opnd0       = op0_q;
    assign opnd1       = op1_q;
    assign dst_out     = dst_q;
    assign sel_illegal = ill_q;
  end else begin : g_comb
    assign opnd0       = opnd_d[0];
    assign opnd1       = opnd_d[1];
    assign dst_out     = dst_d;
    assign sel_illegal = ill_d;
  end
endmodule

// File: rtl/subdw_sel_merge_chk.sv
module subdw_sel_merge_chk #(
  parameter int DW      = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] src0,
  input logic [2:0]    src0_sel,
  input logic          src0_sext,
  input logic [DW-1:0] src1,
  input logic [2:0]    src1_sel,
  input logic          src1_sext,
  input logic [DW-1:0] alu_res,
  input logic [DW-1:0] dst_old,
  input logic [2:0]    dst_sel,
  input logic [1:0]    dst_fill,
  input logic [DW-1:0] opnd0,
  input logic [DW-1:0] opnd1,
  input logic [DW-1:0] dst_out,
  input logic          sel_illegal
);
  localparam int BW = DW / 4;
  localparam int HW = DW / 2;

  if (OUT_REG) begin : g_chk
    a_r1_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (src1_sel <= 3'd3 && !src1_sext) |=> (opnd1[DW-1:BW] == '0));

    a_r2_half_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
      ((src0_sel == 3'd4 || src0_sel == 3'd5) && src0_sext)
        |=> (opnd0[DW-1:HW] == {HW{opnd0[HW-1]}}));

    a_r3_dword_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (src0_sel == 3'd6) |=> (opnd0 == $past(src0)));

    a_r4_low_half_field: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_sel == 3'd4) |=> (dst_out[HW-1:0] == $past(alu_res[HW-1:0])));

    a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_sel == 3'd5 && dst_fill == 2'd0) |=> (dst_out[HW-1:0] == '0));

    a_r6_sign_below: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_sel == 3'd3 && dst_fill == 2'd1) |=> (dst_out[DW-BW-1:0] == '0));

    a_r7_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_sel == 3'd0 && dst_fill == 2'd2)
        |=> (dst_out[DW-1:BW] == $past(dst_old[DW-1:BW])));

    a_r8_dword_dst: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_sel == 3'd6) |=> (dst_out == $past(alu_res)));

    a_r9_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (src0_sel == 3'd7 || dst_fill == 2'd3) |=> sel_illegal);
  end
endmodule

bind subdw_sel_merge subdw_sel_merge_chk #(.DW(DW), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_subdw_sel_merge.sv
module sim_subdw_sel_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src0 = '0, src1 = '0, alu_res = '0, dst_old = '0;
  logic [2:0]  src0_sel = 3'd6, src1_sel = 3'd6, dst_sel = 3'd6;
  logic        src0_sext = 1'b0, src1_sext = 1'b0;
  logic [1:0]  dst_fill = 2'd2;
  logic [31:0] opnd0, opnd1, dst_out;
  logic        sel_illegal;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] o0, o1, d;
    logic        ill;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  subdw_sel_merge u0 (
    .clk(clk), .rst_n(rst_n),
    .src0(src0), .src0_sel(src0_sel), .src0_sext(src0_sext),
    .src1(src1), .src1_sel(src1_sel), .src1_sext(src1_sext),
    .alu_res(alu_res), .dst_old(dst_old), .dst_sel(dst_sel), .dst_fill(dst_fill),
    .opnd0(opnd0), .opnd1(opnd1), .dst_out(dst_out), .sel_illegal(sel_illegal)
  );

  function automatic logic [31:0] m_src(logic [31:0] s, logic [2:0] c, logic x);
    logic [31:0] v;
    int w;
    case (c)
      3'd0: begin v = s & 32'hFF;        w = 8;  end
      3'd1: begin v = (s >> 8) & 32'hFF;  w = 8;  end
      3'd2: begin v = (s >> 16) & 32'hFF; w = 8;  end
      3'd3: begin v = s >> 24;            w = 8;  end
      3'd4: begin v = s & 32'hFFFF;       w = 16; end
      3'd5: begin v = s >> 16;            w = 16; end
      default: begin v = s;               w = 32; end
    endcase
    if (x && w < 32 && v[w-1]) v = v | (32'hFFFF_FFFF << w);
    return v;
  endfunction

  function automatic logic [31:0] m_dst(logic [31:0] r, logic [31:0] o,
                                        logic [2:0] c, logic [1:0] f);
    int lo, w;
    logic [63:0] fm, am, bm, fv;
    case (c)
      3'd0, 3'd1, 3'd2, 3'd3: begin lo = 8 * c; w = 8; end
      3'd4: begin lo = 0;  w = 16; end
      3'd5: begin lo = 16; w = 16; end
      default: begin lo = 0; w = 32; end
    endcase
    fm = ((64'd1 << w) - 1) << lo;
    bm = (64'd1 << lo) - 1;
    am = 64'hFFFF_FFFF & ~(fm | bm);
    fv = ({32'd0, r} & ((64'd1 << w) - 1)) << lo;
    case (f)
      2'd0: return fv[31:0];
      2'd1: return fv[31:0] | (r[w-1] ? am[31:0] : 32'd0);
      default: return fv[31:0] | (o & ~fm[31:0]);
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic [31:0] s0, logic [2:0] c0, logic x0,
                       logic [31:0] s1, logic [2:0] c1, logic x1,
                       logic [31:0] r, logic [31:0] o, logic [2:0] dc, logic [1:0] f);
    exp_t e;
    @(negedge clk);
    src0 = s0; src0_sel = c0; src0_sext = x0;
    src1 = s1; src1_sel = c1; src1_sext = x1;
    alu_res = r; dst_old = o; dst_sel = dc; dst_fill = f;
    e.o0  = m_src(s0, c0, x0);
    e.o1  = m_src(s1, c1, x1);
    e.d   = m_dst(r, o, dc, f);
    e.ill = (c0 == 3'd7) || (c1 == 3'd7) || (dc == 3'd7) || (f == 2'd3);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: one edge of latency (R10)
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " opnd0"}, opnd0, e.o0);
      check({e.tag, " opnd1"}, opnd1, e.o1);
      check({e.tag, " dst"}, dst_out, e.d);
      check({e.tag, " illegal"}, {31'd0, sel_illegal}, {31'd0, e.ill});
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    src0 = 32'hDEAD_BEEF; alu_res = 32'h1234_5678; src0_sel = 3'd0;
    repeat (3) @(posedge clk);
    #2;
    check("R10 reset opnd0", opnd0, 32'd0);
    check("R10 reset dst", dst_out, 32'd0);
    check("R10 reset illegal", {31'd0, sel_illegal}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 byte/half lanes, zero extension
    drive("R1 b1", 32'h8899_AABB, 3'd1, 0, 32'h8899_AABB, 3'd3, 0, 32'h0, 32'h0, 3'd6, 2'd2);
    drive("R1 h1", 32'hF00F_1234, 3'd5, 0, 32'hF00F_8234, 3'd4, 0, 32'h0, 32'h0, 3'd6, 2'd2);
    // R2 sign extension, top bit set and clear
    drive("R2 sext", 32'h0080_7F80, 3'd0, 1, 32'h8000_7FFF, 3'd5, 1, 32'h0, 32'h0, 3'd6, 2'd2);
    drive("R2 sext pos", 32'h0080_7F80, 3'd1, 1, 32'h8000_7FFF, 3'd4, 1, 32'h0, 32'h0, 3'd6, 2'd2);
    // R3 whole word ignores sext
    drive("R3 dword", 32'h8000_0001, 3'd6, 1, 32'hFFFF_0000, 3'd6, 0, 32'h0, 32'h0, 3'd6, 2'd0);
    // R4..R7 destination policies
    drive("R4 R5 zero b2", 32'h0, 3'd6, 0, 32'h0, 3'd6, 0, 32'h0000_00C3, 32'hFFFF_FFFF, 3'd2, 2'd0);
    drive("R4 R6 sign b1", 32'h0, 3'd6, 0, 32'h0, 3'd6, 0, 32'h0000_0081, 32'hFFFF_FFFF, 3'd1, 2'd1);
    drive("R6 sign pos h0", 32'h0, 3'd6, 0, 32'h0, 3'd6, 0, 32'hFFFF_7001, 32'hFFFF_FFFF, 3'd4, 2'd1);
    drive("R6 sign b3", 32'h0, 3'd6, 0, 32'h0, 3'd6, 0, 32'h0000_00FE, 32'hFFFF_FFFF, 3'd3, 2'd1);
    drive("R4 R7 keep h1", 32'h0, 3'd6, 0, 32'h0, 3'd6, 0, 32'h0000_BEEF, 32'h1234_5678, 3'd5, 2'd2);
    drive("R7 keep b0", 32'h0, 3'd6, 0, 32'h0, 3'd6, 0, 32'hAAAA_AA5A, 32'h1234_5678, 3'd0, 2'd2);
    // R8 whole word destination under every policy
    for (int f = 0; f < 3; f++)
      drive("R8 dword dst", 32'h0, 3'd6, 0, 32'h0, 3'd6, 0, 32'h8765_4321, 32'h0F0F_0F0F, 3'd6, 2'(f));
    // R9 illegal codes
    drive("R9 src code7", 32'hC001_D00D, 3'd7, 1, 32'h1, 3'd6, 0, 32'h5, 32'h7, 3'd6, 2'd2);
    drive("R9 dst code7", 32'h1, 3'd6, 0, 32'h1, 3'd6, 0, 32'hCAFE_F00D, 32'h7, 3'd7, 2'd0);
    drive("R9 fill code3", 32'h1, 3'd6, 0, 32'h1, 3'd6, 0, 32'h0000_0012, 32'hABCD_EF01, 3'd2, 2'd3);
    drive("R9 legal clear", 32'h1, 3'd0, 0, 32'h1, 3'd5, 1, 32'h1, 32'h1, 3'd1, 2'd1);
    // mixed random traffic
    for (int n = 0; n < 300; n++)
      drive("R1 R2 R4 R5 R6 R7 mix", $urandom, 3'($urandom), 1'($urandom),
            $urandom, 3'($urandom), 1'($urandom), $urandom, $urandom,
            3'($urandom), 2'($urandom));
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule